// File: doc/BRIEF.md
# Link Transmitter Parallel Front-End

This block sits between an application data buffer and the serializer of a serial link transmitter. It divides the core clock into word slots of `SLOT_CYCLES` cycles. In every slot it either pulls one word from the application or, when the application has nothing ready, sends a stuffing word so the serial line keeps its alignment. The application sees a one-cycle read pulse. It presents its word while that pulse is high, and the block takes the word at the clock edge that ends the pulse.

The block always sends the even parity it computes itself over the word. When self-parity mode is off, the application supplies its own parity bit. The block compares that bit with its own result and reports any difference on a registered active-low error output, but it still sends the correct parity. A rising edge on the frame-mark input raises a pending request. That request is attached to the next word that leaves the block, whether that word is data or stuffing.

The reset is synchronous and active high, and the clock is the core clock. An asynchronous active-low board reset is expected to be synchronized and inverted before it reaches this block. The frame-mark input is expected to be synchronous to the core clock.

Top module: `lfe_tx_front`

## Requirements
- R1: While `rst` is high, at the next edge `read_pulse` and `out_vld` go to 0, `parity_err_n` goes to 1 and no mark request is pending.
- R2: Slot boundaries fall at every `SLOT_CYCLES`-th clock edge after reset. `read_pulse` goes high for exactly one cycle after a boundary edge at which `rdy_in` is 1, and it is never high at any other time.
- R3: At the edge that ends a `read_pulse`, `app_data` is captured. In the following cycle `out_vld`=1 and `out_stuff`=0, and `out_data` holds the captured word.
- R4: A slot boundary with `rdy_in`=0 produces a stuffing word in the next cycle, with `out_vld`=1, `out_stuff`=1, `out_data`=0 and `out_parity`=0.
- R5: `out_parity` is the XOR of all 36 bits of the word being sent (even parity), whatever the value of `app_parity`.
- R6: With `self_parity`=0, `parity_err_n` is updated with each captured word. It is 0 when `app_parity` differs from the XOR of `app_data` and 1 when they match, and it holds its value between words.
- R7: With `self_parity`=1, `app_parity` has no effect and `parity_err_n` is 1 in the cycle after.
- R8: A 0-to-1 change of `mark_in` sets a pending request. The next emitted word (data or stuffing) carries `out_mark`=1, and that word clears the request. A rising edge in the same cycle as an emission is attached to that word.
- R9: Several rising edges of `mark_in` that arrive before the request is attached mark only one word.
- R10: `out_vld` is high at most once per slot, and only for the data or stuffing word of that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| rdy_in | input | 1 | Application has a word ready |
| app_data | input | 36 | Application word, valid while `read_pulse` is high |
| app_parity | input | 1 | Application-supplied parity bit |
| self_parity | input | 1 | 1 = ignore `app_parity` and use internal parity only |
| mark_in | input | 1 | End-of-frame mark request, rising-edge sensitive |
| read_pulse | output | 1 | One-cycle read strobe to the application |
| out_vld | output | 1 | A word is presented to the serializer this cycle |
| out_data | output | 36 | Outgoing word (zero for stuffing) |
| out_parity | output | 1 | Even parity of `out_data` |
| out_mark | output | 1 | Frame mark attached to this word |
| out_stuff | output | 1 | This word is a stuffing word |
| parity_err_n | output | 1 | Parity mismatch of the last checked word, active low |

## Verification
The assertions assume that `SLOT_CYCLES` is at least 2, so a read pulse and the slot boundary that follows it never fall in the same cycle. They also assume that `mark_in` and `rdy_in` change only between clock edges. The bench drives every input at the falling clock edge from seeded `$urandom` draws and keeps the mark input low during reset. Its stimulus phases vary how often the application is ready, wrong application parity in both parity modes, and mark edge density, and a directed sequence places two mark edges inside one slot.

// File: rtl/lfe_pkg.sv
package lfe_pkg;
  // What the front-end hands to the serializer in a given cycle.
  typedef enum logic [1:0] {
    EMIT_NONE  = 2'd0,
    EMIT_DATA  = 2'd1,
    EMIT_STUFF = 2'd2
  } emit_e;
endpackage

// File: rtl/lfe_slot_timer.sv
module lfe_slot_timer #(
  parameter int SLOT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rdy_in,
  output logic read_pulse,
  output logic stuff_slot
);
  localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          boundary;

  assign boundary   = (cnt == LAST);
  assign stuff_slot = boundary & ~rdy_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      read_pulse <= 1'b0;
    end else begin
      cnt        <= boundary ? '0 : cnt + CW'(1);
      read_pulse <= boundary & rdy_in;
    end
  end

  initial begin
    a_r2_slot_min : assert (SLOT_CYCLES >= 2);
  end

  // R2: the strobe lasts a single cycle
  a_r2_single_pulse : assert property (@(posedge clk) disable iff (rst)
    read_pulse |=> !read_pulse);

  // R2: the strobe only follows a slot edge at which the application was ready
  a_r2_needs_ready : assert property (@(posedge clk) disable iff (rst)
    read_pulse |-> $past(rdy_in));
endmodule

// File: rtl/lfe_parity_unit.sv
module lfe_parity_unit #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              self_parity,
  input  logic              capture,
  input  logic [DATA_W-1:0] app_data,
  input  logic              app_parity,
  output logic              calc_parity,
  output logic              parity_err_n
);
  assign calc_parity = ^app_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      parity_err_n <= 1'b1;
    end else if (self_parity) begin
      parity_err_n <= 1'b1;
    end else if (capture) begin
      parity_err_n <= (app_parity == calc_parity);
    end
  end

  // R7: error flag is inactive whenever self-parity mode was on
  a_r7_err_quiet : assert property (@(posedge clk) disable iff (rst)
    self_parity |=> parity_err_n);

  // R6: without a captured word in external mode the flag holds
  a_r6_err_holds : assert property (@(posedge clk) disable iff (rst)
    (!capture && !self_parity) |=> $stable(parity_err_n));
endmodule

// File: rtl/lfe_mark_capture.sv
module lfe_mark_capture (
  input  logic clk,
  input  logic rst,
  input  logic mark_in,
  input  logic attach,
  output logic mark_now
);
  logic mark_q;
  logic pending;
  logic rise;

  assign rise     = mark_in & ~mark_q;
  assign mark_now = pending | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_q  <= 1'b0;
      pending <= 1'b0;
    end else begin
      mark_q  <= mark_in;
      pending <= attach ? 1'b0 : (pending | rise);
    end
  end

  // R8: an attached request is gone afterwards
  a_r8_clear_on_attach : assert property (@(posedge clk) disable iff (rst)
    attach |=> !pending);

  // R9: a request waits, unmerged edges add nothing new while pending
  a_r9_pending_sticks : assert property (@(posedge clk) disable iff (rst)
    (pending && !attach) |=> pending);
endmodule

// File: rtl/lfe_tx_front.sv
module lfe_tx_front #(
  parameter int DATA_W      = 36,
  parameter int SLOT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdy_in,
  input  logic [DATA_W-1:0] app_data,
  input  logic              app_parity,
  input  logic              self_parity,
  input  logic              mark_in,
  output logic              read_pulse,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic              out_parity,
  output logic              out_mark,
  output logic              out_stuff,
  output logic              parity_err_n
);
  import lfe_pkg::*;

  logic  stuff_slot;
  logic  calc_parity;
  logic  mark_now;
  logic  attach;
  emit_e emit;

  lfe_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .rdy_in     (rdy_in),
    .read_pulse (read_pulse),
    .stuff_slot (stuff_slot)
  );

  lfe_parity_unit #(.DATA_W(DATA_W)) u_parity (
    .clk          (clk),
    .rst          (rst),
    .self_parity  (self_parity),
    .capture      (read_pulse),
    .app_data     (app_data),
    .app_parity   (app_parity),
    .calc_parity  (calc_parity),
    .parity_err_n (parity_err_n)
  );

  lfe_mark_capture u_mark (
    .clk      (clk),
    .rst      (rst),
    .mark_in  (mark_in),
    .attach   (attach),
    .mark_now (mark_now)
  );

  always_comb begin
    if (read_pulse)      emit = EMIT_DATA;
    else if (stuff_slot) emit = EMIT_STUFF;
    else                 emit = EMIT_NONE;
  end

  assign attach = (emit != EMIT_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld    <= 1'b0;
      out_data   <= '0;
      out_parity <= 1'b0;
      out_mark   <= 1'b0;
      out_stuff  <= 1'b0;
    end else begin
      out_vld <= attach;
      case (emit)
        EMIT_DATA: begin
          out_data   <= app_data;
          out_parity <= calc_parity;
          out_mark   <= mark_now;
          out_stuff  <= 1'b0;
        end
        EMIT_STUFF: begin
          out_data   <= '0;
          out_parity <= 1'b0;
          out_mark   <= mark_now;
          out_stuff  <= 1'b1;
        end
        default: begin
          out_mark   <= 1'b0;
          out_stuff  <= 1'b0;
        end
      endcase
    end
  end

  // R1: reset clears the outward state at the next edge
  a_r1_reset_state : assert property (@(posedge clk)
    rst |=> (!out_vld && !read_pulse && parity_err_n));

  // R3: a read strobe is followed by a data word
  a_r3_data_follows : assert property (@(posedge clk) disable iff (rst)
    read_pulse |=> (out_vld && !out_stuff));

  // R4: stuffing words carry no payload
  a_r4_stuff_empty : assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_stuff) |-> (out_data == '0 && !out_parity));

  // R5: every emitted word has even parity including its parity bit
  a_r5_even : assert property (@(posedge clk) disable iff (rst)
    out_vld |-> !(^{out_data, out_parity}));

  // R10: no two words in back-to-back data/stuff collision
  a_r10_no_overlap : assert property (@(posedge clk) disable iff (rst)
    !(read_pulse && stuff_slot));
endmodule

// File: tb/tb_lfe_tx_front.sv
module tb_lfe_tx_front;
  localparam int W    = 36;
  localparam int SLOT = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         rdy_in;
  logic [W-1:0] app_data;
  logic         app_parity;
  logic         self_parity;
  logic         mark_in;
  logic         read_pulse, out_vld, out_parity, out_mark, out_stuff, parity_err_n;
  logic [W-1:0] out_data;

  lfe_tx_front #(.DATA_W(W), .SLOT_CYCLES(SLOT)) dut (
    .clk(clk), .rst(rst), .rdy_in(rdy_in), .app_data(app_data),
    .app_parity(app_parity), .self_parity(self_parity), .mark_in(mark_in),
    .read_pulse(read_pulse), .out_vld(out_vld), .out_data(out_data),
    .out_parity(out_parity), .out_mark(out_mark), .out_stuff(out_stuff),
    .parity_err_n(parity_err_n)
  );

  always #4 clk = ~clk;

  int total = 0;
  int passed = 0;
  int cyc = 0;

  // bench-side expectation state
  int   e;
  bit   m_stb, m_pend, m_mprev, m_err;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s: actual %0h expected %0h", req, act, exp);
  endtask

  function automatic logic [W-1:0] rand_word();
    return {4'($urandom), $urandom};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

  // one clock: advance model with the inputs applied at the edge, compare outputs
  task automatic step();
    bit tick, rise, emit_d, emit_s, exp_flag;
    @(posedge clk);
    @(negedge clk);
    e++;
    tick   = (e % SLOT) == 0;
    rise   = mark_in & ~m_mprev;
    m_mprev = mark_in;
    emit_d = m_stb;
    emit_s = tick & ~rdy_in;
    exp_flag = m_pend | rise;
    if (emit_d || emit_s) m_pend = 1'b0;
    else                  m_pend = m_pend | rise;
    if (self_parity)  m_err = 1'b1;
    else if (emit_d)  m_err = (app_parity == ^app_data);
    m_stb = tick & rdy_in;

    chk(read_pulse == m_stb, "R2 read_pulse", 64'(read_pulse), 64'(m_stb));
    chk(out_vld == (emit_d | emit_s), "R10 out_vld", 64'(out_vld), 64'(emit_d | emit_s));
    if (self_parity) chk(parity_err_n == m_err, "R7 parity_err_n", 64'(parity_err_n), 64'(m_err));
    else             chk(parity_err_n == m_err, "R6 parity_err_n", 64'(parity_err_n), 64'(m_err));
    if (emit_d) begin
      chk(out_data == app_data && !out_stuff, "R3 data word", 64'(out_data), 64'(app_data));
      chk(out_parity == ^app_data, "R5 parity", 64'(out_parity), 64'(^app_data));
      chk(out_mark == exp_flag, "R8 mark on data", 64'(out_mark), 64'(exp_flag));
    end else if (emit_s) begin
      chk(out_stuff && out_data == '0 && !out_parity, "R4 stuffing", 64'({out_stuff, out_parity, out_data}),
          64'({1'b1, 1'b0, 36'h0}));
      chk(out_mark == exp_flag, "R8 mark on stuff", 64'(out_mark), 64'(exp_flag));
    end
  endtask

  task automatic drive_rand(input int rdy_pct, input bit sp, input int mark_pct, input int bad_pct);
    logic [W-1:0] d;
    d = rand_word();
    app_data    = d;
    rdy_in      = ($urandom % 100) < rdy_pct;
    self_parity = sp;
    app_parity  = (^d) ^ (($urandom % 100) < bad_pct);
    if (($urandom % 100) < mark_pct) mark_in = ~mark_in;
  endtask

  initial begin
    int flagged;
    void'($urandom(32'd20240611));
    rst = 1'b1; rdy_in = 1'b0; app_data = '0; app_parity = 1'b0;
    self_parity = 1'b0; mark_in = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: state after reset
    chk(read_pulse == 1'b0, "R1 read_pulse", 64'(read_pulse), 64'd0);
    chk(out_vld == 1'b0, "R1 out_vld", 64'(out_vld), 64'd0);
    chk(parity_err_n == 1'b1, "R1 parity_err_n", 64'(parity_err_n), 64'd1);
    chk(out_mark == 1'b0, "R1 out_mark", 64'(out_mark), 64'd0);
    rst = 1'b0;
    e = 0; m_stb = 0; m_pend = 0; m_mprev = 0; m_err = 1;

    // random phases: ready density, parity mode, mark activity, bad parity rate
    for (int i = 0; i < 400; i++) begin step(); drive_rand(100, 1'b0, 10, 20); end
    for (int i = 0; i < 400; i++) begin step(); drive_rand(50,  1'b0, 30, 40); end
    for (int i = 0; i < 400; i++) begin step(); drive_rand(0,   1'b0, 20, 0);  end
    for (int i = 0; i < 400; i++) begin step(); drive_rand(80,  1'b1, 25, 100); end
    for (int i = 0; i < 400; i++) begin step(); drive_rand(70,  1'b0, 50, 50); end
    for (int i = 0; i < 400; i++) begin step(); drive_rand(100, 1'b0, 0, 100); end

    // directed R9: two mark edges inside one slot flag a single word
    mark_in = 1'b0; rdy_in = 1'b1; self_parity = 1'b0;
    for (int i = 0; i < 3 * SLOT; i++) step();
    for (int i = 0; i < 2 * SLOT && !out_vld; i++) step();
    flagged = 0;
    mark_in = 1'b1; step(); if (out_vld && out_mark) flagged++;
    mark_in = 1'b0; step(); if (out_vld && out_mark) flagged++;
    mark_in = 1'b1; step(); if (out_vld && out_mark) flagged++;
    mark_in = 1'b0;
    for (int i = 0; i < 12; i++) begin step(); if (out_vld && out_mark) flagged++; end
    chk(flagged == 1, "R9 merged marks", 64'(flagged), 64'd1);

    // directed R7: wrong parity ignored in self mode
    self_parity = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step();
      app_data = rand_word(); app_parity = ~(^app_data);
    end
    chk(parity_err_n == 1'b1, "R7 self mode quiet", 64'(parity_err_n), 64'd1);

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule